// File: doc/BRIEF.md
# Ternary Relation Comparator

This block compares two unsigned ternary numbers, A and B, each one or two digits wide, and reports a single relation between them. A three-valued control picks that relation: greater-than, equality or less-than. The answer comes back as one ternary digit, high level for true and low level for false. The block is purely combinational and has no clock or state.

Every ternary digit is carried on two wires. The datapath is built only from radix-3 selectors. A 3:1 selector steers one of three digits by a ternary select. A 9:1 selector is built from four 3:1 selectors: three of them pick by the low select digit, and a fourth picks among their outputs by the high select digit.

Each digit pair is turned into an order digit by a 9:1 selector that reads a constant table. The order digits are chained from the most significant position downward. A final 9:1 selector, addressed by the relation control and the overall order, gives the verdict. Any illegal code on the control or on an operand digit forces the output to false.

Top module: `tern_cmp`

## Requirements
- R1: Each ternary digit uses two bits, with 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2, and 2'b11 is illegal; the output is 2'b10 for a true relation and 2'b00 for a false one.
- R2: With `sel_i` = 0 (2'b00) the output is true exactly when A is numerically greater than B.
- R3: With `sel_i` = 1 (2'b01) the output is true exactly when A equals B.
- R4: With `sel_i` = 2 (2'b10) the output is true exactly when A is numerically less than B.
- R5: Digit k of an operand sits in bits [2k+1:2k], and the operand's value is the sum of digit k times 3^k, so the highest digit is the most significant.
- R6: When the most significant digits of A and B differ, they alone decide the relation, whatever the lower digits hold.
- R7: When the most significant digits are equal, the next lower digits decide the relation.
- R8: When `sel_i` = 2'b11 the output is 2'b00 for every operand value.
- R9: When any digit of A or B is 2'b11 the output is 2'b00 for every select value.
- R10: The output never takes any value other than 2'b00 or 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 2*DIGITS | Operand A, ternary digits, two bits each |
| b_i | input | 2*DIGITS | Operand B, ternary digits, two bits each |
| sel_i | input | 2 | Relation control: 0 greater, 1 equal, 2 less |
| y_o | output | 2 | Verdict: 2'b10 true, 2'b00 false |

## Verification
The bench sweeps every code on both operands and on the control, 1024 combinations with two digits, illegal codes included. Pairs whose high digits differ but whose low digits point the other way separate a correct most-significant-first decision from one driven by the low digit. Pairs with equal high digits show whether the low digit takes over. Equal operands separate the equality relation from the two strict ones, and the combinations with a 2'b11 code show whether an illegal control and an illegal operand are each forced to false independently of the other inputs.

// File: rtl/tern_cmp_pkg.sv
package tern_cmp_pkg;

  // two-bit carrier of one ternary digit
  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_0   = 2'b00;
  localparam trit_t TRIT_1   = 2'b01;
  localparam trit_t TRIT_2   = 2'b10;
  localparam trit_t TRIT_BAD = 2'b11;

  // order digit meaning: A above B, A equal to B, A below B
  localparam trit_t ORD_ABOVE = TRIT_0;
  localparam trit_t ORD_SAME  = TRIT_1;
  localparam trit_t ORD_BELOW = TRIT_2;

  // levels driven on the verdict
  localparam trit_t VERDICT_TRUE  = TRIT_2;
  localparam trit_t VERDICT_FALSE = TRIT_0;

  function automatic logic trit_is_legal(input trit_t t);
    return t != TRIT_BAD;
  endfunction

endpackage

// File: rtl/tern_mux3.sv
module tern_mux3
  import tern_cmp_pkg::*;
(
  input  trit_t sel,
  input  trit_t d0,
  input  trit_t d1,
  input  trit_t d2,
  output trit_t y
);

  always_comb begin
    case (sel)
      TRIT_0:  y = d0;
      TRIT_1:  y = d1;
      TRIT_2:  y = d2;
      default: y = TRIT_0;
    endcase
  end

endmodule

// File: rtl/tern_mux9.sv
module tern_mux9
  import tern_cmp_pkg::*;
(
  input  trit_t sel_hi,
  input  trit_t sel_lo,
  input  trit_t d [9],
  output trit_t y
);

  localparam int GROUPS = 3;

  trit_t stage1 [GROUPS];

  // first rank: one selector per group of three, steered by the low digit
  for (genvar g = 0; g < GROUPS; g++) begin : g_rank1
    tern_mux3 u_lo (
      .sel (sel_lo),
      .d0  (d[3*g+0]),
      .d1  (d[3*g+1]),
      .d2  (d[3*g+2]),
      .y   (stage1[g])
    );
  end

  // second rank: picks a group by the high digit
  tern_mux3 u_hi (
    .sel (sel_hi),
    .d0  (stage1[0]),
    .d1  (stage1[1]),
    .d2  (stage1[2]),
    .y   (y)
  );

endmodule

// File: rtl/tern_digit_order.sv
module tern_digit_order
  import tern_cmp_pkg::*;
(
  input  trit_t a,
  input  trit_t b,
  output trit_t order
);

  trit_t table_q [9];

  // constant table indexed by 3*a + b
  for (genvar k = 0; k < 9; k++) begin : g_tbl
    localparam int VA = k / 3;
    localparam int VB = k % 3;
    if (VA > VB) begin : g_above
      assign table_q[k] = ORD_ABOVE;
    end else if (VA == VB) begin : g_same
      assign table_q[k] = ORD_SAME;
    end else begin : g_below
      assign table_q[k] = ORD_BELOW;
    end
  end

  tern_mux9 u_tbl (
    .sel_hi (a),
    .sel_lo (b),
    .d      (table_q),
    .y      (order)
  );

endmodule

// File: rtl/tern_cmp.sv
module tern_cmp
  import tern_cmp_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic [2*DIGITS-1:0] a_i,
  input  logic [2*DIGITS-1:0] b_i,
  input  logic [1:0]          sel_i,
  output logic [1:0]          y_o
);

  localparam int W = 2 * DIGITS;

  trit_t digit_ord [DIGITS];
  trit_t chain_ord [DIGITS];
  trit_t verdict_tbl [9];
  trit_t verdict_raw;
  logic  [DIGITS-1:0] digit_ok;
  logic  operands_ok;

  // per-digit order and legality
  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    tern_digit_order u_ord (
      .a     (a_i[2*i +: 2]),
      .b     (b_i[2*i +: 2]),
      .order (digit_ord[i])
    );
    assign digit_ok[i] = trit_is_legal(a_i[2*i +: 2]) & trit_is_legal(b_i[2*i +: 2]);
  end

  // most significant digit first; a tie hands the decision downward
  assign chain_ord[DIGITS-1] = digit_ord[DIGITS-1];
  for (genvar i = DIGITS - 2; i >= 0; i--) begin : g_chain
    tern_mux3 u_link (
      .sel (chain_ord[i+1]),
      .d0  (ORD_ABOVE),
      .d1  (digit_ord[i]),
      .d2  (ORD_BELOW),
      .y   (chain_ord[i])
    );
  end

  // verdict table indexed by 3*select + order: true where they agree
  for (genvar k = 0; k < 9; k++) begin : g_vtbl
    if ((k / 3) == (k % 3)) begin : g_hit
      assign verdict_tbl[k] = VERDICT_TRUE;
    end else begin : g_miss
      assign verdict_tbl[k] = VERDICT_FALSE;
    end
  end

  tern_mux9 u_verdict (
    .sel_hi (sel_i),
    .sel_lo (chain_ord[0]),
    .d      (verdict_tbl),
    .y      (verdict_raw)
  );

  assign operands_ok = &digit_ok;

  always_comb begin
    if (operands_ok) y_o = verdict_raw;
    else             y_o = VERDICT_FALSE;
  end

  logic unused_w;
  assign unused_w = ^W;

endmodule

// File: rtl/tern_cmp_chk.sv
module tern_cmp_chk #(
  parameter int DIGITS = 2
) (
  input logic [2*DIGITS-1:0] a_i,
  input logic [2*DIGITS-1:0] b_i,
  input logic [1:0]          sel_i,
  input logic [1:0]          y_o
);

  localparam int TOP = DIGITS - 1;

  logic any_bad;
  logic [1:0] a_top, b_top;

  always_comb begin
    any_bad = 1'b0;
    for (int i = 0; i < DIGITS; i++) begin
      if (a_i[2*i +: 2] == 2'b11 || b_i[2*i +: 2] == 2'b11) any_bad = 1'b1;
    end
    a_top = a_i[2*TOP +: 2];
    b_top = b_i[2*TOP +: 2];
  end

  always_comb begin
    AST_OUT_LEVEL: assert (y_o == 2'b00 || y_o == 2'b10); // R10
    if (sel_i == 2'b11) begin
      AST_BAD_SEL_FALSE: assert (y_o == 2'b00); // R8
    end
    if (any_bad) begin
      AST_BAD_DIGIT_FALSE: assert (y_o == 2'b00); // R9
    end
    if (!any_bad && a_i == b_i && sel_i != 2'b11) begin
      AST_EQUAL_ONLY_SAME: assert (y_o == ((sel_i == 2'b01) ? 2'b10 : 2'b00)); // R3
    end
    if (!any_bad && a_top > b_top && sel_i != 2'b11) begin
      AST_TOP_DIGIT_RULES: assert (y_o == ((sel_i == 2'b00) ? 2'b10 : 2'b00)); // R6
    end
  end

endmodule

bind tern_cmp tern_cmp_chk #(.DIGITS(DIGITS)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .sel_i (sel_i),
  .y_o   (y_o)
);

// File: tb/tb_tern_cmp.sv
`timescale 1ns/1ps
module tb_tern_cmp;

  localparam int DIGITS = 2;
  localparam int W      = 2 * DIGITS;
  localparam int CODES  = 1 << W;

  logic clk;
  logic rst_n;
  logic [W-1:0] a_i, b_i;
  logic [1:0]   sel_i;
  logic [1:0]   y_o;

  int n_checks;
  int n_fail;
  bit done;

  tern_cmp #(.DIGITS(DIGITS)) dut (
    .a_i   (a_i),
    .b_i   (b_i),
    .sel_i (sel_i),
    .y_o   (y_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // value of an operand per R1/R5, or -1 when a digit is illegal
  function automatic int tern_value(input logic [W-1:0] v);
    int acc = 0;
    int wgt = 1;
    for (int i = 0; i < DIGITS; i++) begin
      int d = int'(v[2*i +: 2]);
      if (d == 3) return -1;
      acc += d * wgt;
      wgt *= 3;
    end
    return acc;
  endfunction

  task automatic check(input logic [1:0] got, input logic [1:0] exp, input string req);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%b b=%b sel=%b got=%b expected=%b", req, a_i, b_i, sel_i, got, exp);
    end
  endtask

  initial begin
    a_i = '0; b_i = '0; sel_i = 2'b00;
    n_checks = 0; n_fail = 0; done = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: zero operands, greater-than requested -> false (R2)
    check(y_o, 2'b00, "R2 reset");
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < CODES; a++) begin
        for (int b = 0; b < CODES; b++) begin
          int va, vb;
          logic [1:0] exp;
          string tag;
          @(posedge clk);
          #1;
          sel_i = 2'(s); a_i = W'(a); b_i = W'(b);
          @(negedge clk);
          va = tern_value(W'(a));
          vb = tern_value(W'(b));
          if (s == 3) begin
            exp = 2'b00; tag = "R8";
          end else if (va < 0 || vb < 0) begin
            exp = 2'b00; tag = "R9";
          end else begin
            bit rel;
            case (s)
              0: begin rel = va > vb;  tag = "R2"; end
              1: begin rel = va == vb; tag = "R3"; end
              default: begin rel = va < vb; tag = "R4"; end
            endcase
            exp = rel ? 2'b10 : 2'b00;
            // tag the digit-priority cases, R5 weighting assumed
            if (a_i[W-1 -: 2] != b_i[W-1 -: 2]) tag = {tag, "/R6"};
            else                                tag = {tag, "/R7"};
          end
          check(y_o, exp, tag);
          // R10 and R1 output encoding
          check((y_o == 2'b00 || y_o == 2'b10) ? 2'b00 : 2'b11, 2'b00, "R10/R1 level");
        end
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule